// File: doc/BRIEF.md
# Interrupt Source Priority Selector

This block is the presentation stage of an interrupt controller serving a parameterised number of sources. Each source has a pending input and a programmable priority level held in a small register bank. A lower level number is more favoured. The all-ones level marks a source as masked. On every clock the block works out which pending source the CPU should see. It then registers that source's index and level, and asserts an interrupt request when the level beats the CPU's current priority.

Selection works in two stages and uses no chain of comparators. First, a per-level occupancy vector marks every level that holds at least one pending source, and a lowest-set-bit encoder picks the most favoured occupied level. Second, a per-source vector marks the pending sources at that level, and a second encoder of the same kind picks the lowest-numbered one. A parameter chooses how the encoders are built: a plain scan, or a trailing-zero count that isolates the lowest set bit with the two's-complement trick.

Top module: `irq_prio_select`

## Requirements
- R1: After reset every priority register reads as masked (all ones). A write with `prio_we_i` high stores `prio_wdata_i` into the register of source `prio_idx_i` at that clock edge. The new level takes part in selection from the next edge onward.
- R2: `sel_prio_o` is the numerically smallest level among sources that are pending and not masked.
- R3: `sel_src_o` is the lowest-numbered source that is pending at the selected level.
- R4: A source whose level is all ones (255 at the default 8-bit width) is never selected, even while it is pending.
- R5: `irq_req_o` is high exactly when a source is selected and its level is strictly less than `cpu_prio_i`. An equal level does not raise a request.
- R6: When no unmasked source is pending, the outputs are `sel_src_o` = 0, `sel_prio_o` = all ones and `irq_req_o` = 0.
- R7: All three outputs are registered. Values sampled at clock edge k appear after edge k and stay until edge k+1. This holds for pending inputs, `cpu_prio_i` and the stored priorities.
- R8: While `rst_n` is low (asynchronous, active low), the outputs show the idle values of R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | NSRC | Pending flag per source |
| prio_we_i | input | 1 | Priority register write strobe |
| prio_idx_i | input | $clog2(NSRC) | Source whose priority is written |
| prio_wdata_i | input | PW | Priority level to store |
| cpu_prio_i | input | PW | Current CPU priority |
| sel_src_o | output | $clog2(NSRC) | Selected source index |
| sel_prio_o | output | PW | Selected priority level (all ones when none) |
| irq_req_o | output | 1 | Interrupt request to the CPU |

## Verification
The assertions rely on a few properties of the inputs:
- `pend_i`, `cpu_prio_i` and the write port are synchronous to `clk` and stable around each rising edge.
- A write addresses an index below NSRC.
- Reset is applied at the start of the run.

The stimulus meets these by driving every input at the falling edge from a single sequence, and by drawing write indices only from the valid range. Random levels include the masked value often enough to exercise R4 in mixed patterns.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

   // Build variant of the lowest-set-bit encoders.
   typedef enum logic [0:0] {
      ENC_SCAN    = 1'b0,
      ENC_ISOLATE = 1'b1
   } enc_style_e;

   // Index width that never collapses to zero.
   function automatic int idx_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/prio_bank.sv
module prio_bank #(
   parameter int NSRC = 16,
   parameter int PW   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we_i,
   input  logic [$clog2(NSRC)-1:0]   idx_i,
   input  logic [PW-1:0]             wdata_i,
   output logic [NSRC-1:0][PW-1:0]   level_o
);
   localparam logic [PW-1:0] MASKED = '1;

   // One register per source; reset leaves every source masked.
   for (genvar s = 0; s < NSRC; s++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            level_o[s] <= MASKED;
         else if (we_i && (idx_i == s[$clog2(NSRC)-1:0]))
            level_o[s] <= wdata_i;
      end
   end

endmodule

// File: rtl/level_occupancy.sv
module level_occupancy #(
   parameter int NSRC = 16,
   parameter int PW   = 8
) (
   input  logic [NSRC-1:0]           pend_i,
   input  logic [NSRC-1:0][PW-1:0]   level_i,
   output logic [(1<<PW)-1:0]        occ_o
);
   localparam int NLVL = 1 << PW;

   // Each pending source lights the bit of its level; the masked level is dropped.
   always_comb begin
      occ_o = '0;
      for (int s = 0; s < NSRC; s++) begin
         if (pend_i[s])
            occ_o[level_i[s]] = 1'b1;
      end
      occ_o[NLVL-1] = 1'b0;
   end

endmodule

// File: rtl/source_match.sv
module source_match #(
   parameter int NSRC = 16,
   parameter int PW   = 8
) (
   input  logic [NSRC-1:0]           pend_i,
   input  logic [NSRC-1:0][PW-1:0]   level_i,
   input  logic [PW-1:0]             best_lvl_i,
   input  logic                      lvl_found_i,
   output logic [NSRC-1:0]           match_o
);
   for (genvar s = 0; s < NSRC; s++) begin : g_cmp
      assign match_o[s] = lvl_found_i && pend_i[s] && (level_i[s] == best_lvl_i);
   end

endmodule

// File: rtl/lsb_index.sv
module lsb_index
   import irq_sel_pkg::*;
#(
   parameter int         W     = 16,
   parameter enc_style_e STYLE = ENC_ISOLATE
) (
   input  logic [W-1:0]             vec_i,
   output logic [$clog2(W)-1:0]     idx_o,
   output logic                     found_o
);
   localparam int IW = $clog2(W);
   localparam int P  = 1 << IW;

   assign found_o = |vec_i;

   if (STYLE == ENC_SCAN) begin : g_scan
      // Walk down from the top so the lowest set bit is the last one kept.
      always_comb begin
         idx_o = '0;
         for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i])
               idx_o = IW'(i);
         end
      end
   end else begin : g_iso
      // v & -v keeps only the lowest set bit; each index bit is then an OR
      // over the positions whose own index has that bit set.
      logic [P-1:0] padded;
      logic [P-1:0] lowest;

      if (P > W) begin : g_pad
         assign padded = {{(P - W){1'b0}}, vec_i};
      end else begin : g_nopad
         assign padded = vec_i;
      end

      assign lowest = padded & (~padded + 1'b1);

      for (genvar b = 0; b < IW; b++) begin : g_bit
         logic [P-1:0] sel_mask;
         for (genvar i = 0; i < P; i++) begin : g_m
            assign sel_mask[i] = ((i >> b) & 1) == 1;
         end
         assign idx_o[b] = |(lowest & sel_mask);
      end
   end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
   import irq_sel_pkg::*;
#(
   parameter int         NSRC = 16,
   parameter int         PW   = 8,
   parameter enc_style_e ENC  = ENC_ISOLATE
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSRC-1:0]           pend_i,
   input  logic                      prio_we_i,
   input  logic [$clog2(NSRC)-1:0]   prio_idx_i,
   input  logic [PW-1:0]             prio_wdata_i,
   input  logic [PW-1:0]             cpu_prio_i,
   output logic [$clog2(NSRC)-1:0]   sel_src_o,
   output logic [PW-1:0]             sel_prio_o,
   output logic                      irq_req_o
);
   localparam int            IW     = $clog2(NSRC);
   localparam int            NLVL   = 1 << PW;
   localparam logic [PW-1:0] MASKED = '1;

   // Elaboration-time parameter checks.
   if (NSRC < 2) begin : g_err_nsrc
      $error("irq_prio_select: NSRC must be at least 2");
   end
   if (PW < 2 || PW > 10) begin : g_err_pw
      $error("irq_prio_select: PW must lie in 2..10");
   end

   logic [NSRC-1:0][PW-1:0] prio_q;
   logic [NLVL-1:0]         occ;
   logic [PW-1:0]           best_lvl;
   logic                    lvl_found;
   logic [NSRC-1:0]         match;
   logic [IW-1:0]           best_src;
   logic                    src_found;

   logic [IW-1:0]           nxt_src;
   logic [PW-1:0]           nxt_prio;
   logic                    nxt_req;

   prio_bank #(.NSRC(NSRC), .PW(PW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (prio_we_i),
      .idx_i   (prio_idx_i),
      .wdata_i (prio_wdata_i),
      .level_o (prio_q)
   );

   // Stage 1: which levels are occupied, then the most favoured one.
   level_occupancy #(.NSRC(NSRC), .PW(PW)) u_occ (
      .pend_i  (pend_i),
      .level_i (prio_q),
      .occ_o   (occ)
   );

   lsb_index #(.W(NLVL), .STYLE(ENC)) u_enc_lvl (
      .vec_i   (occ),
      .idx_o   (best_lvl),
      .found_o (lvl_found)
   );

   // Stage 2: sources pending at that level, then the lowest-numbered one.
   source_match #(.NSRC(NSRC), .PW(PW)) u_match (
      .pend_i      (pend_i),
      .level_i     (prio_q),
      .best_lvl_i  (best_lvl),
      .lvl_found_i (lvl_found),
      .match_o     (match)
   );

   lsb_index #(.W(NSRC), .STYLE(ENC)) u_enc_src (
      .vec_i   (match),
      .idx_o   (best_src),
      .found_o (src_found)
   );

   always_comb begin
      if (lvl_found && src_found) begin
         nxt_src  = best_src;
         nxt_prio = best_lvl;
         nxt_req  = best_lvl < cpu_prio_i;
      end else begin
         nxt_src  = '0;
         nxt_prio = MASKED;
         nxt_req  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_src_o  <= '0;
         sel_prio_o <= MASKED;
         irq_req_o  <= 1'b0;
      end else begin
         sel_src_o  <= nxt_src;
         sel_prio_o <= nxt_prio;
         irq_req_o  <= nxt_req;
      end
   end

endmodule

// File: rtl/irq_prio_select_chk.sv
module irq_prio_select_chk #(
   parameter int NSRC = 16,
   parameter int PW   = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSRC-1:0]           pend_i,
   input  logic [NSRC-1:0][PW-1:0]   prio_q,
   input  logic [PW-1:0]             cpu_prio_i,
   input  logic [$clog2(NSRC)-1:0]   sel_src_o,
   input  logic [PW-1:0]             sel_prio_o,
   input  logic                      irq_req_o
);
   localparam logic [PW-1:0] MASKED = '1;

   // Copies of what the selector saw at the previous edge.
   logic [NSRC-1:0]         pend_d;
   logic [NSRC-1:0][PW-1:0] prio_d;
   logic [PW-1:0]           cpu_d;
   logic                    lower_tie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_d <= '0;
         prio_d <= {NSRC{MASKED}};
         cpu_d  <= '0;
      end else begin
         pend_d <= pend_i;
         prio_d <= prio_q;
         cpu_d  <= cpu_prio_i;
      end
   end

   always_comb begin
      lower_tie = 1'b0;
      for (int s = 0; s < NSRC; s++) begin
         if (s < int'(sel_src_o) && pend_d[s] && prio_d[s] == sel_prio_o)
            lower_tie = 1'b1;
      end
   end

   a_r6_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_i == '0) |=> (sel_src_o == '0 && sel_prio_o == MASKED && !irq_req_o));

   a_r2_selected_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_prio_o != MASKED) |-> (pend_d[sel_src_o] && prio_d[sel_src_o] == sel_prio_o));

   a_r3_no_lower_tie: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_prio_o != MASKED) |-> !lower_tie);

   a_r4_masked_no_request: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_prio_o == MASKED) |-> (!irq_req_o && sel_src_o == '0));

   a_r5_request_rule: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req_o == (sel_prio_o != MASKED && sel_prio_o < cpu_d));

endmodule

bind irq_prio_select irq_prio_select_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pend_i     (pend_i),
   .prio_q     (prio_q),
   .cpu_prio_i (cpu_prio_i),
   .sel_src_o  (sel_src_o),
   .sel_prio_o (sel_prio_o),
   .irq_req_o  (irq_req_o)
);

// File: tb/test_irq_prio_select.sv
module test_irq_prio_select;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 16;
   localparam int PW   = 8;
   localparam int IW   = $clog2(NSRC);
   localparam int MASK_LVL = (1 << PW) - 1;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NSRC-1:0] pend;
   logic            we;
   logic [IW-1:0]   widx;
   logic [PW-1:0]   wdata;
   logic [PW-1:0]   cpu;
   logic [IW-1:0]   sel_src;
   logic [PW-1:0]   sel_prio;
   logic            irq_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;
   string tag = "R8";

   int mprio [NSRC];
   int exp_src, exp_prio, exp_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_prio_select #(.NSRC(NSRC), .PW(PW)) i_irq_prio_select (
      .clk          (clk),
      .rst_n        (rst_n),
      .pend_i       (pend),
      .prio_we_i    (we),
      .prio_idx_i   (widx),
      .prio_wdata_i (wdata),
      .cpu_prio_i   (cpu),
      .sel_src_o    (sel_src),
      .sel_prio_o   (sel_prio),
      .irq_req_o    (irq_req)
   );

   task automatic check(input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Behavioural reference: scan for the best level, then the first source at it.
   task automatic predict();
      int best;
      best = MASK_LVL;
      for (int s = 0; s < NSRC; s++)
         if (pend[s] && mprio[s] != MASK_LVL && mprio[s] < best) best = mprio[s];
      exp_src = 0; exp_prio = MASK_LVL; exp_req = 0;
      if (best != MASK_LVL) begin
         for (int s = NSRC - 1; s >= 0; s--)
            if (pend[s] && mprio[s] == best) exp_src = s;
         exp_prio = best;
         exp_req  = (best < int'(cpu)) ? 1 : 0;
      end
   endtask

   task automatic compare_all();
      check("sel_src", int'(sel_src), exp_src);
      check("sel_prio", int'(sel_prio), exp_prio);
      check("irq_req", int'(irq_req), exp_req);
   endtask

   // One clock: predict from the pre-edge inputs, update the model, compare after.
   task automatic step();
      @(posedge clk);
      predict();
      if (we) mprio[widx] = int'(wdata);
      @(negedge clk);
      compare_all();
   endtask

   task automatic write_prio(input int idx, input int val);
      we = 1'b1; widx = IW'(idx); wdata = PW'(val);
      step();
      we = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; pend = '0; we = 1'b0; widx = '0; wdata = '0; cpu = '0;
      for (int s = 0; s < NSRC; s++) mprio[s] = MASK_LVL;

      // R8: outputs idle while reset is held, even with sources pending.
      tag = "R8";
      exp_src = 0; exp_prio = MASK_LVL; exp_req = 0;
      repeat (2) @(negedge clk);
      pend = '1; cpu = '1;
      repeat (2) begin @(negedge clk); compare_all(); end
      rst_n = 1'b1;

      // R1/R4: after reset all levels are masked, so nothing is selected.
      tag = "R4";
      repeat (3) step();

      // R6: nothing pending.
      tag = "R6";
      pend = '0;
      repeat (3) step();

      // R1: program distinct levels; each takes effect one edge after its write.
      tag = "R1";
      pend = '1;
      for (int s = 0; s < NSRC; s++) write_prio(s, 40 + ((s * 7) % 16));
      step();

      // R2: pick the minimum across varied pending patterns.
      tag = "R2";
      pend = 16'h00F0; step();
      pend = 16'h8001; step();
      pend = 16'h5A5A; step();

      // R3: ties at one level resolve to the lowest index.
      tag = "R3";
      write_prio(9, 3); write_prio(4, 3); write_prio(12, 3);
      pend = 16'h1210; step(); step();
      pend = 16'h1200; step();

      // R4: mask the favoured source while it stays pending.
      tag = "R4";
      write_prio(9, MASK_LVL);
      step();
      pend = 16'h0200; step(); step();

      // R5: strict comparison against the CPU level.
      tag = "R5";
      pend = 16'h1000; cpu = 8'd3; step(); step();
      cpu = 8'd4; step(); step();
      cpu = 8'd2; step(); step();

      // R7: random traffic compared every clock against one-cycle latency.
      tag = "R7";
      for (int n = 0; n < 3000; n++) begin
         pend = NSRC'($urandom);
         if ($urandom_range(0, 3) == 0) pend = NSRC'(1 << $urandom_range(0, NSRC - 1));
         cpu  = PW'($urandom_range(0, 64));
         we   = ($urandom_range(0, 2) == 0);
         widx = IW'($urandom_range(0, NSRC - 1));
         wdata = ($urandom_range(0, 4) == 0) ? PW'(MASK_LVL) : PW'($urandom_range(0, 63));
         step();
      end
      we = 1'b0; pend = '0;
      tag = "R6";
      step(); step();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule